// File: doc/BRIEF.md
# Link Power-State Controller

This block runs the power management of each lane in a multi-lane signal repeater. Each lane has its own state machine. The state machine watches four inputs: a synchronized activity flag from the lane's input comparator, the lane's active-low enable, a shared switch that turns load probing on or off, and the results of an external load-probing sequencer. From these it chooses one of five power states. The block drives the output squelch and the termination select for the lane, and it asks the sequencer for a load probe when one is needed. A shared power-down flag tells the rest of the chip when every lane is parked.

Two idle windows control the power saving. Both are counted in clock cycles and set by parameters. The short window moves an active lane whose input has gone quiet into a light sleep. The longer window, counted while the lane sleeps, starts a new probe for a far-end load. When a probe finds no load, the lane parks in a disconnected state and keeps probing until a load appears. Any input activity wakes a sleeping or disconnected lane on the next clock. With load probing switched off, a lane moves only between running and sleeping, and its terminations stay engaged.

Top module: `lps_ctrl`

## Requirements
- R1: Each lane's state appears on `pstate` in bits [3i+2:3i] for lane i, encoded as 0 = standby, 1 = probing, 2 = running, 3 = sleeping, 4 = disconnected. After reset every lane is in standby. A high `en_n[i]` moves lane i to standby at the next clock edge, whatever state it was in and whatever the other inputs are.
- R2: `chip_pd` is high exactly when every lane is in standby. It is high on the clock edge that follows a cycle in which all enables were high.
- R3: A standby lane whose enable is low moves, at the next edge, to probing if `rxdet_en` is high and to running if it is low.
- R4: A running lane moves to sleeping after SLUMBER_CYC consecutive clock edges with `sig_det` low. Any cycle with `sig_det` high restarts that count.
- R5: A sleeping or disconnected lane whose `sig_det` is high moves to running at the next edge. This takes priority over an idle timeout or a probe result arriving in the same cycle.
- R6: A sleeping lane with `rxdet_en` high moves to probing after REDET_CYC consecutive idle edges counted in the sleeping state. With `rxdet_en` low it stays sleeping however long the input stays idle.
- R7: In probing, a `det_done` pulse moves the lane to sleeping if `load_ok` is high and to disconnected if it is low. If `rxdet_en` goes low while the lane is probing, the lane moves to running.
- R8: In disconnected, a `det_done` with `load_ok` high moves the lane to sleeping. A `det_done` with `load_ok` low keeps the lane disconnected and raises `det_req` in the next cycle, so probing continues. If `rxdet_en` goes low, the lane moves to running.
- R9: `det_req[i]` is high in the first cycle of every stay in probing, and for one cycle after each no-load result. It is never high in any other state.
- R10: `squelch[i]` is low only while lane i is running and its `sig_det` is high at that moment. In every other case the output is held at common mode.
- R11: `term_on[i]` is low in standby, and low in disconnected while `rxdet_en` is high. It is high in every other case.
- R12: Lanes are independent. The inputs of one lane never change the state of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_n | input | NCH | Per-lane active-low enable |
| rxdet_en | input | 1 | Load probing switch, shared by all lanes |
| sig_det | input | NCH | Synchronized input-activity flag per lane |
| load_ok | input | NCH | Probe result: far-end load present |
| det_done | input | NCH | Probe finished; `load_ok` is valid |
| pstate | output | 3*NCH | Per-lane power state, 3 bits each |
| squelch | output | NCH | Hold output at common mode |
| det_req | output | NCH | Start a load probe |
| term_on | output | NCH | Low-impedance termination engaged |
| chip_pd | output | 1 | All lanes in standby |

## Verification
The hazardous coincidences happen when a wake-up from input activity lands in the same cycle as another transition. One case is a sleeping lane whose activity returns on the very edge where the re-probe window runs out. Another is a disconnected lane that sees activity and a load-found result together. The bench steers a lane into both situations on purpose and expects the lane to be running after the edge. It also checks that an enable going high overrides everything else. In the random phase a bench model replays the priorities cycle by cycle, so every output of both lanes is compared against the model after each edge.

// File: rtl/lps_pkg.sv
package lps_pkg;

  typedef enum logic [2:0] {
    PS_STANDBY = 3'd0,
    PS_DETECT  = 3'd1,
    PS_ACTIVE  = 3'd2,
    PS_SLUMBER = 3'd3,
    PS_UNPLUG  = 3'd4
  } pstate_e;

  // True when the edge about to happen completes `lim` idle edges.
  function automatic logic idle_reached(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lps_idle_cnt.sv
module lps_idle_cnt #(
  parameter int unsigned MAXC = 16,
  parameter int unsigned W    = $clog2(MAXC + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = W'(MAXC);

  // Saturating counter of consecutive idle edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lps_chan_fsm.sv
module lps_chan_fsm
  import lps_pkg::*;
#(
  parameter int unsigned SLUMBER_CYC = 8,
  parameter int unsigned REDET_CYC   = 16,
  parameter int unsigned CNT_W       = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_n,
  input  logic       rxdet_en,
  input  logic       sig_det,
  input  logic       load_ok,
  input  logic       det_done,
  output logic [2:0] state_o,
  output logic       det_req,
  output logic       squelch,
  output logic       term_on
);
  localparam int unsigned MAXC = max2(SLUMBER_CYC, REDET_CYC);

  pstate_e          st_q, nxt;
  logic [CNT_W-1:0] idle_cnt;
  logic             idle_clr;
  logic             sleep_due;
  logic             reprobe_due;
  logic             rearm;
  logic             req_d;

  lps_idle_cnt #(.MAXC(MAXC), .W(CNT_W)) u_idle (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (idle_clr),
    .cnt   (idle_cnt)
  );

  assign sleep_due   = !sig_det && idle_reached(32'(idle_cnt), SLUMBER_CYC);
  assign reprobe_due = rxdet_en && idle_reached(32'(idle_cnt), REDET_CYC);

  always_comb begin
    nxt = st_q;
    if (en_n) begin
      nxt = PS_STANDBY;
    end else begin
      unique case (st_q)
        PS_STANDBY: nxt = rxdet_en ? PS_DETECT : PS_ACTIVE;
        PS_DETECT: begin
          if (!rxdet_en)     nxt = PS_ACTIVE;
          else if (det_done) nxt = load_ok ? PS_SLUMBER : PS_UNPLUG;
        end
        PS_ACTIVE: begin
          if (sleep_due) nxt = PS_SLUMBER;
        end
        PS_SLUMBER: begin
          if (sig_det)          nxt = PS_ACTIVE;
          else if (reprobe_due) nxt = PS_DETECT;
        end
        PS_UNPLUG: begin
          if (sig_det || !rxdet_en)     nxt = PS_ACTIVE;
          else if (det_done && load_ok) nxt = PS_SLUMBER;
        end
        default: nxt = PS_STANDBY;
      endcase
    end
  end

  assign idle_clr = sig_det || (nxt != st_q);
  assign rearm    = (nxt == PS_UNPLUG) && det_done && !load_ok;
  assign req_d    = ((nxt == PS_DETECT) && (st_q != PS_DETECT)) || rearm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PS_STANDBY;
      det_req <= 1'b0;
    end else begin
      st_q    <= nxt;
      det_req <= req_d;
    end
  end

  assign state_o = st_q;
  assign squelch = !((st_q == PS_ACTIVE) && sig_det);
  assign term_on = (st_q != PS_STANDBY) && !((st_q == PS_UNPLUG) && rxdet_en);
endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
  import lps_pkg::*;
#(
  parameter int unsigned NCH         = 2,
  parameter int unsigned SLUMBER_CYC = 130000,
  parameter int unsigned REDET_CYC   = 600000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   en_n,
  input  logic             rxdet_en,
  input  logic [NCH-1:0]   sig_det,
  input  logic [NCH-1:0]   load_ok,
  input  logic [NCH-1:0]   det_done,
  output logic [3*NCH-1:0] pstate,
  output logic [NCH-1:0]   squelch,
  output logic [NCH-1:0]   det_req,
  output logic [NCH-1:0]   term_on,
  output logic             chip_pd
);
  localparam int unsigned MAXC  = max2(SLUMBER_CYC, REDET_CYC);
  localparam int unsigned CNT_W = $clog2(MAXC + 1);

  logic [NCH-1:0] parked;

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    logic [2:0] st;

    lps_chan_fsm #(
      .SLUMBER_CYC (SLUMBER_CYC),
      .REDET_CYC   (REDET_CYC),
      .CNT_W       (CNT_W)
    ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_n     (en_n[i]),
      .rxdet_en (rxdet_en),
      .sig_det  (sig_det[i]),
      .load_ok  (load_ok[i]),
      .det_done (det_done[i]),
      .state_o  (st),
      .det_req  (det_req[i]),
      .squelch  (squelch[i]),
      .term_on  (term_on[i])
    );

    assign pstate[3*i +: 3] = st;
    assign parked[i]        = (st == PS_STANDBY);
  end

  assign chip_pd = &parked;
endmodule

// File: rtl/lps_ctrl_chk.sv
module lps_ctrl_chk #(
  parameter int unsigned NCH = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   en_n,
  input logic             rxdet_en,
  input logic [NCH-1:0]   sig_det,
  input logic [NCH-1:0]   load_ok,
  input logic [NCH-1:0]   det_done,
  input logic [3*NCH-1:0] pstate,
  input logic [NCH-1:0]   squelch,
  input logic [NCH-1:0]   det_req,
  input logic [NCH-1:0]   term_on,
  input logic             chip_pd
);
  a_r2_all_off_pd: assert property (@(posedge clk) disable iff (!rst_n)
    (&en_n) |=> chip_pd);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    logic [2:0] st;
    assign st = pstate[3*i +: 3];

    a_r1_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
      en_n[i] |=> (st == 3'd0));

    a_r3_leave_standby: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == 3'd0) && !en_n[i]) |=> (st == ($past(rxdet_en) ? 3'd1 : 3'd2)));

    a_r5_activity_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      (((st == 3'd3) || (st == 3'd4)) && sig_det[i] && !en_n[i]) |=> (st == 3'd2));

    a_r6_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == 3'd3) && !sig_det[i] && !rxdet_en && !en_n[i]) |=> (st == 3'd3));

    a_r7_no_load: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == 3'd1) && !en_n[i] && rxdet_en && det_done[i] && !load_ok[i]) |=> (st == 3'd4));

    a_r9_req_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (st != 3'd1) ##1 (st == 3'd1) |-> det_req[i]);

    a_r9_req_where: assert property (@(posedge clk) disable iff (!rst_n)
      det_req[i] |-> ((st == 3'd1) || (st == 3'd4)));

    a_r10_drive_only_active: assert property (@(posedge clk) disable iff (!rst_n)
      !squelch[i] |-> ((st == 3'd2) && sig_det[i]));

    a_r11_standby_open: assert property (@(posedge clk) disable iff (!rst_n)
      (st == 3'd0) |-> !term_on[i]);
  end
endmodule

bind lps_ctrl lps_ctrl_chk #(.NCH(NCH)) u_lps_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_n     (en_n),
  .rxdet_en (rxdet_en),
  .sig_det  (sig_det),
  .load_ok  (load_ok),
  .det_done (det_done),
  .pstate   (pstate),
  .squelch  (squelch),
  .det_req  (det_req),
  .term_on  (term_on),
  .chip_pd  (chip_pd)
);

// File: tb/lps_ctrl_bench.sv
module lps_ctrl_bench;
  localparam int NCH = 2;
  localparam int SL  = 6;
  localparam int RD  = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NCH-1:0]   en_n;
  logic             rxdet_en;
  logic [NCH-1:0]   sig_det;
  logic [NCH-1:0]   load_ok;
  logic [NCH-1:0]   det_done;
  logic [3*NCH-1:0] pstate;
  logic [NCH-1:0]   squelch;
  logic [NCH-1:0]   det_req;
  logic [NCH-1:0]   term_on;
  logic             chip_pd;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  lps_ctrl #(.NCH(NCH), .SLUMBER_CYC(SL), .REDET_CYC(RD)) u_lps_ctrl (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .rxdet_en(rxdet_en),
    .sig_det(sig_det), .load_ok(load_ok), .det_done(det_done),
    .pstate(pstate), .squelch(squelch), .det_req(det_req),
    .term_on(term_on), .chip_pd(chip_pd)
  );

  // Reference model of the lane state rules.
  int mst  [NCH];
  int mcnt [NCH];
  bit mreq [NCH];

  function automatic int model_next(int s, bit off, bit rx, bit sg, bit dn, bit ld, int c);
    if (off) return 0;
    case (s)
      0: return rx ? 1 : 2;
      1: begin
        if (!rx) return 2;
        if (dn)  return ld ? 3 : 4;
        return 1;
      end
      2: return (!sg && (c + 1 >= SL)) ? 3 : 2;
      3: begin
        if (sg) return 2;
        if (rx && (c + 1 >= RD)) return 1;
        return 3;
      end
      4: begin
        if (sg || !rx)  return 2;
        if (dn && ld)   return 3;
        return 4;
      end
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n) begin
        mst[c] = 0; mcnt[c] = 0; mreq[c] = 0;
      end else begin
        int n;
        n = model_next(mst[c], en_n[c], rxdet_en, sig_det[c], det_done[c], load_ok[c], mcnt[c]);
        mreq[c] = (n == 1 && mst[c] != 1) || (n == 4 && det_done[c] && !load_ok[c]);
        if (sig_det[c] || n != mst[c]) mcnt[c] = 0;
        else if (mcnt[c] < RD)         mcnt[c] = mcnt[c] + 1;
        mst[c] = n;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int ps(input int c);
    return int'(pstate[3*c +: 3]);
  endfunction

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; en_n = 2'b11; rxdet_en = 1'b0;
    sig_det = 2'b11; load_ok = 2'b00; det_done = 2'b00;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1 reset standby lane0", ps(0), 0);
    chk("R1 reset standby lane1", ps(1), 0);
    chk("R2 pd all off", chip_pd, 1);

    // Enable lane0 without probing
    en_n = 2'b10;
    tick(1);
    chk("R3 standby to running", ps(0), 2);
    chk("R2 pd dropped", chip_pd, 0);
    chk("R10 driving", squelch[0], 0);
    sig_det[0] = 1'b0; #1;
    chk("R10 quiet input squelched", squelch[0], 1);
    tick(5);
    chk("R4 still running before window", ps(0), 2);
    tick(1);
    chk("R4 sleeping after window", ps(0), 3);
    sig_det[0] = 1'b1;
    tick(1);
    chk("R5 wake from sleep", ps(0), 2);
    sig_det[0] = 1'b0; tick(4);
    sig_det[0] = 1'b1; tick(1);
    sig_det[0] = 1'b0; tick(5);
    chk("R4 count restarted by activity", ps(0), 2);
    tick(1);
    chk("R4 sleeps after restarted window", ps(0), 3);
    tick(20);
    chk("R6 no probing when switch low", ps(0), 3);
    chk("R11 termination engaged", term_on[0], 1);
    chk("R9 no request", det_req[0], 0);

    en_n = 2'b11;
    tick(1);
    chk("R1 disable from sleep", ps(0), 0);
    chk("R11 standby termination off", term_on[0], 0);

    // Probing path
    rxdet_en = 1'b1; en_n = 2'b10;
    tick(1);
    chk("R3 standby to probing", ps(0), 1);
    chk("R9 request on entry", det_req[0], 1);
    tick(1);
    chk("R9 request single cycle", det_req[0], 0);
    chk("R7 waits for result", ps(0), 1);
    det_done[0] = 1'b1; load_ok[0] = 1'b0;
    tick(1);
    det_done[0] = 1'b0;
    chk("R7 no load to disconnected", ps(0), 4);
    chk("R8 rearm request", det_req[0], 1);
    chk("R11 disconnected termination off", term_on[0], 0);
    tick(1);
    chk("R8 rearm single cycle", det_req[0], 0);
    chk("R8 stays disconnected", ps(0), 4);
    det_done[0] = 1'b1; load_ok[0] = 1'b1;
    tick(1);
    det_done[0] = 1'b0;
    chk("R8 load found to sleeping", ps(0), 3);
    tick(9);
    chk("R6 sleeping before reprobe window", ps(0), 3);
    tick(1);
    chk("R6 reprobe after window", ps(0), 1);
    chk("R9 reprobe request", det_req[0], 1);
    det_done[0] = 1'b1; load_ok[0] = 1'b1;
    tick(1);
    det_done[0] = 1'b0;
    chk("R7 load to sleeping", ps(0), 3);
    tick(9);
    sig_det[0] = 1'b1;
    tick(1);
    chk("R5 activity beats reprobe timeout", ps(0), 2);
    sig_det[0] = 1'b0;

    en_n = 2'b11; tick(1);
    en_n = 2'b10; tick(1);
    det_done[0] = 1'b1; load_ok[0] = 1'b0; tick(1);
    chk("R7 disconnected again", ps(0), 4);
    load_ok[0] = 1'b1; sig_det[0] = 1'b1;
    tick(1);
    chk("R5 activity beats load result", ps(0), 2);
    det_done[0] = 1'b0; sig_det[0] = 1'b0;

    en_n = 2'b11; tick(1);
    en_n = 2'b10; tick(1);
    chk("R3 probing", ps(0), 1);
    rxdet_en = 1'b0;
    tick(1);
    chk("R7 switch off while probing", ps(0), 2);
    chk("R12 lane1 untouched", ps(1), 0);
    sig_det[1] = 1'b1; en_n = 2'b00;
    tick(1);
    chk("R12 lane1 runs alone", ps(1), 2);

    // Random phase against the model
    for (int k = 0; k < 3000; k++) begin
      bit allpd;
      allpd = 1;
      for (int c = 0; c < NCH; c++) begin
        bit exq;
        bit ext;
        exq = !(mst[c] == 2 && sig_det[c]);
        ext = (mst[c] != 0) && !(mst[c] == 4 && rxdet_en);
        if (mst[c] != 0) allpd = 0;
        chk($sformatf("R12 lane%0d state", c), ps(c), mst[c]);
        chk($sformatf("R9 lane%0d request", c), det_req[c], mreq[c]);
        chk($sformatf("R10 lane%0d squelch", c), squelch[c], exq);
        chk($sformatf("R11 lane%0d termination", c), term_on[c], ext);
      end
      chk("R2 pd", chip_pd, allpd);
      for (int c = 0; c < NCH; c++) begin
        if ($urandom_range(39) == 0) en_n[c] = ~en_n[c];
        sig_det[c]  = ($urandom_range(11) == 0);
        det_done[c] = ($urandom_range(5) == 0);
        load_ok[c]  = $urandom_range(1);
      end
      if ($urandom_range(199) == 0) rxdet_en = ~rxdet_en;
      tick(1);
    end

    finish_run();
  end
endmodule